// File: doc/BRIEF.md
# Reference-Clock Stall and Skew Monitor

This block watches a monitored main clock for two faults: a stall, where the clock stops, and frequency skew, where it keeps running at the wrong rate. All of its logic runs from an independent reference clock, so it keeps working when the monitored clock or the PLL behind it stops. In the monitored domain there is only a single toggle flop. Its output crosses into the reference domain through a synchronizer chain. In the reference domain, each change of that output becomes a one-cycle edge pulse.

The block has two checks. The stall check counts reference cycles since the last edge pulse. It raises a stall when that count reaches a programmed timeout. The skew check counts edge pulses over fixed windows of reference cycles and compares each total with an inclusive lower and upper limit. A single bad window is treated as noise. A skew is flagged only when two windows in a row fall outside the limits.

Both fault flags latch until reset. A stall is a loss of trust in the timebase and requests the hold-off level. A skew on its own requests the degrade level. Monitoring starts only after a settle interval that follows reset release.

Top module: `refclk_stall_monitor`

## Requirements
- R1: While reset is asserted and at reset release, `stall_flag`, `skew_flag` and `safe_req` are low and `safe_level` is 2'b00.
- R2: For the first SETTLE_CYC reference cycles after the internal reset is released, neither fault flag rises, even if the monitored clock is stopped.
- R3: Once the block is armed, a stall is flagged when no monitored edge arrives for `stall_timeout` reference cycles. The flag rises within `stall_timeout`+8 reference cycles of the last monitored rising edge.
- R4: A monitored clock whose edges are never `stall_timeout` cycles apart never sets `stall_flag`.
- R5: Each window is WIN_CYC reference cycles long. Its edge count is in range when `cnt_lo` <= count <= `cnt_hi`, limits included. `skew_flag` is set when two consecutive windows are out of range, whether too few or too many edges.
- R6: A single out-of-range window between in-range windows does not set `skew_flag`.
- R7: Skew and stall are separate classes. A gap shorter than the stall timeout but longer than two windows sets `skew_flag` with `stall_flag` low.
- R8: Once set, `stall_flag` and `skew_flag` stay set until reset, even after the monitored clock returns to normal.
- R9: `safe_level` is 2'b11 (hold-off) whenever `stall_flag` is high. It is 2'b01 (degrade) when only `skew_flag` is high, and 2'b00 otherwise. `safe_req` is high exactly when `safe_level` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock; all decisions are made here |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally |
| mon_clk | input | 1 | Monitored main clock |
| stall_timeout | input | TO_W | Quiet reference cycles that count as a stall |
| cnt_lo | input | CNT_W | Lowest acceptable edge count per window |
| cnt_hi | input | CNT_W | Highest acceptable edge count per window |
| stall_flag | output | 1 | Sticky stall indication |
| skew_flag | output | 1 | Sticky frequency-skew indication |
| safe_req | output | 1 | Request to enter the safe state |
| safe_level | output | 2 | Requested level: 00 none, 01 degrade, 11 hold-off |

## Verification
The hardest condition to reach from the ports is a lone bad window. The edge count must drop out of range for exactly one window and never for two windows in a row. The bench makes every monitored period a whole number of reference cycles, so each window holds a fixed count. It then removes four edges with a short pause and sets the limits so that any split of that loss across a window boundary leaves at most one window out of range. A longer pause then shows skew without stall: the stall timeout is set above the gap.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_DEGRADE = 2'b01,
    LVL_HOLD    = 2'b11
  } safe_level_e;
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkmon_edge_xfer.sv
module clkmon_edge_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic mon_arst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic edge_pulse
);
  // monitored domain: one toggle per rising edge
  logic tog_q;
  logic tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge mon_clk or negedge mon_arst_n) begin
    if (!mon_arst_n) tog_q <= 1'b0;
    else             tog_q <= tog_d;
  end

  // reference domain: synchronizer chain plus one history stage
  logic [SYNC_STAGES:0] stage_q;

  generate
    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = tog_q;
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) stage_q[g] <= 1'b0;
        else            stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign edge_pulse = stage_q[SYNC_STAGES] ^ stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/clkmon_stall_timer.sv
module clkmon_stall_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic            edge_pulse,
  input  logic [TO_W-1:0] timeout,
  output logic            stall_hit
);
  localparam int IDLE_W = TO_W + 1;
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [IDLE_W-1:0] idle_q;
  logic [IDLE_W-1:0] idle_d;

  always_comb begin
    idle_d = idle_q;
    if (!armed || edge_pulse)  idle_d = '0;
    else if (idle_q != IDLE_MAX) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  assign stall_hit = armed && (idle_q >= {1'b0, timeout});
endmodule

// File: rtl/clkmon_rate_check.sv
module clkmon_rate_check #(
  parameter int WIN_CYC = 64,
  parameter int CNT_W   = $clog2(WIN_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             edge_pulse,
  input  logic [CNT_W-1:0] cnt_lo,
  input  logic [CNT_W-1:0] cnt_hi,
  output logic             skew_hit
);
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] edges_q, edges_d;
  logic             bad_q, bad_d;
  logic             win_end;
  logic [CNT_W:0]   total;
  logic             out_of_range;

  always_comb begin
    win_end      = (win_q == WIN_LAST);
    total        = {1'b0, edges_q} + {{CNT_W{1'b0}}, edge_pulse};
    out_of_range = (total < {1'b0, cnt_lo}) || (total > {1'b0, cnt_hi});
    skew_hit     = armed && win_end && out_of_range && bad_q;

    win_d   = win_q;
    edges_d = edges_q;
    bad_d   = bad_q;
    if (!armed) begin
      win_d   = '0;
      edges_d = '0;
      bad_d   = 1'b0;
    end else if (win_end) begin
      win_d   = '0;
      edges_d = '0;
      bad_d   = out_of_range;
    end else begin
      win_d = win_q + 1'b1;
      if (edge_pulse && edges_q != CNT_MAX) edges_d = edges_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      edges_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      win_q   <= win_d;
      edges_q <= edges_d;
      bad_q   <= bad_d;
    end
  end
endmodule

// File: rtl/refclk_stall_monitor.sv
module refclk_stall_monitor
  import clkmon_pkg::*;
#(
  parameter int WIN_CYC     = 64,
  parameter int SETTLE_CYC  = 16,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(WIN_CYC + 1)
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             mon_clk,
  input  logic [TO_W-1:0]  stall_timeout,
  input  logic [CNT_W-1:0] cnt_lo,
  input  logic [CNT_W-1:0] cnt_hi,
  output logic             stall_flag,
  output logic             skew_flag,
  output logic             safe_req,
  output logic [1:0]       safe_level
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  logic rst_ref_n;
  logic edge_pulse;
  logic stall_hit;
  logic skew_hit;

  clkmon_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (rst_ref_n)
  );

  clkmon_edge_xfer #(.SYNC_STAGES(SYNC_STAGES)) i_xfer (
    .mon_clk    (mon_clk),
    .mon_arst_n (rst_n),
    .ref_clk    (ref_clk),
    .ref_rst_n  (rst_ref_n),
    .edge_pulse (edge_pulse)
  );

  // settle interval before arming
  logic [SET_W-1:0] settle_q, settle_d;
  logic             armed, armed_d;

  always_comb begin
    settle_d = settle_q;
    armed_d  = armed;
    if (!armed) begin
      if (settle_q == SET_LAST) armed_d  = 1'b1;
      else                      settle_d = settle_q + 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      settle_q <= '0;
      armed    <= 1'b0;
    end else begin
      settle_q <= settle_d;
      armed    <= armed_d;
    end
  end

  clkmon_stall_timer #(.TO_W(TO_W)) i_stall (
    .clk        (ref_clk),
    .rst_n      (rst_ref_n),
    .armed      (armed),
    .edge_pulse (edge_pulse),
    .timeout    (stall_timeout),
    .stall_hit  (stall_hit)
  );

  clkmon_rate_check #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) i_rate (
    .clk        (ref_clk),
    .rst_n      (rst_ref_n),
    .armed      (armed),
    .edge_pulse (edge_pulse),
    .cnt_lo     (cnt_lo),
    .cnt_hi     (cnt_hi),
    .skew_hit   (skew_hit)
  );

  // sticky fault latches
  logic stall_q, stall_d, skew_q, skew_d;

  always_comb begin
    stall_d = stall_q | stall_hit;
    skew_d  = skew_q  | skew_hit;
  end

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      stall_q <= 1'b0;
      skew_q  <= 1'b0;
    end else begin
      stall_q <= stall_d;
      skew_q  <= skew_d;
    end
  end

  safe_level_e level;
  always_comb begin
    if (stall_q)     level = LVL_HOLD;
    else if (skew_q) level = LVL_DEGRADE;
    else             level = LVL_NONE;
  end

  assign stall_flag = stall_q;
  assign skew_flag  = skew_q;
  assign safe_level = level;
  assign safe_req   = (level != LVL_NONE);
endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk #(
  parameter int SETTLE_CYC = 16,
  parameter int TO_W       = 16
) (
  input logic            ref_clk,
  input logic            rst_ref_n,
  input logic            armed,
  input logic            edge_pulse,
  input logic [TO_W-1:0] stall_timeout,
  input logic            stall_flag,
  input logic            skew_flag,
  input logic            safe_req,
  input logic [1:0]      safe_level
);
  localparam int SW = $clog2(SETTLE_CYC + 1) + 1;
  logic [SW-1:0]   since_rel;
  logic [TO_W:0]   quiet;

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) since_rel <= '0;
    else if (since_rel < SW'(SETTLE_CYC)) since_rel <= since_rel + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n)                 quiet <= '0;
    else if (!armed || edge_pulse)  quiet <= '0;
    else if (quiet != '1)           quiet <= quiet + 1'b1;
  end

  // R2
  settle_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (since_rel < SW'(SETTLE_CYC)) |-> (!stall_flag && !skew_flag));

  // R3
  stall_deadline_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (armed && quiet > {1'b0, stall_timeout}) |-> stall_flag);

  // R8
  stall_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    stall_flag |=> stall_flag);

  // R8
  skew_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    skew_flag |=> skew_flag);

  // R9
  hold_level_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    stall_flag |-> (safe_level == 2'b11 && safe_req));

  // R9
  degrade_level_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (skew_flag && !stall_flag) |-> (safe_level == 2'b01 && safe_req));

  // R9
  idle_level_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (!skew_flag && !stall_flag) |-> (safe_level == 2'b00 && !safe_req));
endmodule

bind refclk_stall_monitor clkmon_chk #(.SETTLE_CYC(SETTLE_CYC), .TO_W(TO_W)) i_chk (
  .ref_clk       (ref_clk),
  .rst_ref_n     (rst_ref_n),
  .armed         (armed),
  .edge_pulse    (edge_pulse),
  .stall_timeout (stall_timeout),
  .stall_flag    (stall_flag),
  .skew_flag     (skew_flag),
  .safe_req      (safe_req),
  .safe_level    (safe_level)
);

// File: tb/test_refclk_stall_monitor.sv
`timescale 1ns/1ps
module test_refclk_stall_monitor;
  localparam int CNT_W = 7;
  localparam int TO_W  = 16;

  logic             ref_clk = 1'b0;
  logic             mon_clk = 1'b0;
  logic             rst_n   = 1'b0;
  logic [TO_W-1:0]  stall_timeout = 16'd40;
  logic [CNT_W-1:0] cnt_lo = '0;
  logic [CNT_W-1:0] cnt_hi = '1;
  logic             stall_flag, skew_flag, safe_req;
  logic [1:0]       safe_level;

  int mon_half = 0;
  bit mon_run  = 1'b0;
  int n_chk    = 0;
  int n_fail   = 0;

  refclk_stall_monitor #(.WIN_CYC(64), .SETTLE_CYC(16), .TO_W(TO_W)) i_refclk_stall_monitor (
    .ref_clk (ref_clk), .rst_n (rst_n), .mon_clk (mon_clk),
    .stall_timeout (stall_timeout), .cnt_lo (cnt_lo), .cnt_hi (cnt_hi),
    .stall_flag (stall_flag), .skew_flag (skew_flag),
    .safe_req (safe_req), .safe_level (safe_level)
  );

  always #5 ref_clk = ~ref_clk;

  // monitored clock: edges offset 3 ns from the reference grid
  always begin
    if (mon_run && mon_half != 0) begin
      #3;
      while (mon_run && mon_half != 0) begin
        #(mon_half) mon_clk = ~mon_clk;
      end
    end else begin
      mon_clk = 1'b0;
      @(mon_run or mon_half);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic restart(input int half, input int lo, input int hi, input int tout);
    rst_n = 1'b0;
    mon_run = 1'b0;
    cyc(4);
    cnt_lo = CNT_W'(lo);
    cnt_hi = CNT_W'(hi);
    stall_timeout = TO_W'(tout);
    mon_half = half;
    mon_run = (half != 0);
    cyc(1);
    rst_n = 1'b1;
  endtask

  // {half[7:0], lo[7:0], hi[7:0], tout[15:0], exp_stall, exp_skew}
  localparam int NV = 9;
  localparam logic [41:0] VEC [NV] = '{
    {8'd20, 8'd16, 8'd16,  16'd40,  1'b0, 1'b0}, // R5 count equals both limits
    {8'd20, 8'd17, 8'd30,  16'd40,  1'b0, 1'b1}, // R5 too few edges
    {8'd20, 8'd0,  8'd15,  16'd40,  1'b0, 1'b1}, // R5 too many edges
    {8'd20, 8'd14, 8'd18,  16'd40,  1'b0, 1'b0}, // R4 steady clock
    {8'd35, 8'd14, 8'd18,  16'd100, 1'b0, 1'b1}, // R5 slow clock
    {8'd35, 8'd8,  8'd11,  16'd100, 1'b0, 1'b0}, // R4 slow clock in range
    {8'd0,  8'd0,  8'd100, 16'd40,  1'b1, 1'b0}, // R3 dead clock, zero accepted
    {8'd0,  8'd1,  8'd100, 16'd40,  1'b1, 1'b1}, // R3 R5 dead clock, both classes
    {8'd15, 8'd20, 8'd24,  16'd40,  1'b0, 1'b0}  // R4 fast clock in range
  };

  initial begin : watchdog
    repeat (150000) @(posedge ref_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int t;
    // R1 reset state
    cyc(3);
    chk(!stall_flag && !skew_flag && !safe_req && safe_level == 2'b00,
        "R1 in reset", int'({stall_flag, skew_flag, safe_req, safe_level}), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [41:0] e;
      e = VEC[v];
      restart(int'(e[41:34]), int'(e[33:26]), int'(e[25:18]), int'(e[17:2]));
      cyc(1);
      chk(!stall_flag && !skew_flag && safe_level == 2'b00, "R1 after release",
          int'({stall_flag, skew_flag}), 0);
      cyc(500);
      chk(stall_flag == e[1], $sformatf("R3/R4 stall vec %0d", v), int'(stall_flag), int'(e[1]));
      chk(skew_flag == e[0], $sformatf("R5 skew vec %0d", v), int'(skew_flag), int'(e[0]));
      chk(safe_level == (e[1] ? 2'b11 : (e[0] ? 2'b01 : 2'b00)),
          $sformatf("R9 level vec %0d", v), int'(safe_level),
          e[1] ? 3 : (e[0] ? 1 : 0));
      chk(safe_req == (e[1] | e[0]), $sformatf("R9 req vec %0d", v), int'(safe_req), int'(e[1] | e[0]));
    end

    // R2 settle: dead clock, tiny timeout
    restart(0, 0, 100, 2);
    cyc(10);
    chk(!stall_flag && !skew_flag, "R2 quiet during settle", int'({stall_flag, skew_flag}), 0);
    cyc(30);
    chk(stall_flag, "R2 armed after settle", int'(stall_flag), 1);

    // R3 detection deadline after clock stops
    restart(20, 0, 127, 40);
    cyc(200);
    chk(!stall_flag, "R4 running clock", int'(stall_flag), 0);
    mon_run = 1'b0;
    t = 0;
    while (!stall_flag && t < 200) begin
      cyc(1);
      t++;
    end
    chk(t >= 36 && t <= 48, "R3 stall latency", t, 44);
    chk(safe_level == 2'b11 && safe_req, "R9 hold-off on stall", int'(safe_level), 3);

    // R8 stall stays after clock returns
    mon_run = 1'b1;
    cyc(300);
    chk(stall_flag, "R8 stall sticky", int'(stall_flag), 1);

    // R6 single short dropout, R7 long dropout
    restart(20, 14, 18, 1000);
    cyc(300);
    mon_run = 1'b0;
    cyc(16);
    mon_run = 1'b1;
    cyc(300);
    chk(!skew_flag, "R6 single bad window", int'(skew_flag), 0);
    chk(!stall_flag, "R6 no stall on short gap", int'(stall_flag), 0);
    mon_run = 1'b0;
    cyc(200);
    chk(skew_flag, "R7 skew on long gap", int'(skew_flag), 1);
    chk(!stall_flag, "R7 stall still clear", int'(stall_flag), 0);
    chk(safe_level == 2'b01 && safe_req, "R9 degrade level", int'(safe_level), 1);
    mon_run = 1'b1;
    cyc(300);
    chk(skew_flag, "R8 skew sticky", int'(skew_flag), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule